// File: doc/BRIEF.md
# Serial Signed-Digit Shift-Add Multiply-Accumulate Unit

This block multiplies a signed data sample by one of eight fixed fractional constants and adds the product into a running accumulator. It has no hardware multiplier. Each constant is kept in canonical signed-digit form as two masks. The nonzero mask has a 1 at every digit that is +1 or -1. The sign mask has a 1 only where the digit is -1. A digit scanner picks one nonzero digit per clock. For that digit it issues a right-shift amount and an invert flag. An adder then folds the shifted operand into the accumulator, either adding it or subtracting it exactly. The subtraction uses bit inversion and a carry-in of 1.

A request is a one-cycle `start_i` pulse. It carries the operand, a 3-bit constant index and a flag that says whether to clear the accumulator first. The number of cycles a request takes equals the number of nonzero digits in the chosen constant. The result appears on `result_o` when `done_o` pulses. In a filter datapath, a sequencer steps the index over the taps and feeds the matching samples, so one shift-add unit serves every tap over the output sample period.

Top module: `csd_serial_mac`

## Requirements
- R1: After reset, `result_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: Each constant K is an integer over 2^14, held as 14 digits. Digit bit i (i = 0..13) weighs 2^i/2^14. The nonzero mask marks digits of value +1 or -1, and the sign mask marks only the -1 digits. The index selects K as follows: 0 → 18, 1 → -116, 2 → 429, 3 → -1278, 4 → 5042, 5 → 8192, 6 → 0, 7 → -8191. The nonzero-digit counts of these constants are 2, 3, 5, 3, 5, 1, 0 and 2.
- R3: The accumulator holds, exactly, the sum of data×K over all requests since the last clear. `result_o` is that sum shifted right arithmetically by 14 bits (rounded toward minus infinity). The data is two's complement.
- R4: A request with `clear_i`=1 discards the previous sum before adding. A request with `clear_i`=0 adds to the previous sum.
- R5: A start accepted at a clock edge raises `busy_o` from that edge on. The unit handles exactly one nonzero digit per cycle. `done_o` is high for exactly one cycle, max(D,1) edges after the accepting edge, where D is the nonzero-digit count of the constant. `busy_o` falls at that same edge.
- R6: A `start_i` pulse seen while `busy_o` is 1 is ignored. It changes neither the result nor the completion time of the request in progress.
- R7: A constant with no nonzero digits (index 6) completes after one cycle. It leaves the sum unchanged, or leaves it 0 when `clear_i` is 1.
- R8: Each digit at bit i shifts the sign-extended operand right by 14-i. This amount is always in 1..14. While the unit is idle and no start arrives, `result_o` holds its value.
- R9: Extreme operands, including -32768 and 32767, give exact products. The accumulator does not overflow for at least 64 requests of full-scale magnitude between clears.

Stored codes: the nonzero and sign masks below are written bit 13 down to bit 0.

| Index | K | Nonzero mask | Sign mask |
|-------|---|--------------|-----------|
| 0 | 18 | 00000000010010 | 00000000000000 |
| 1 | -116 | 00000010010100 | 00000010000100 |
| 2 | 429 | 00001001010101 | 00000001010100 |
| 3 | -1278 | 00010100000010 | 00010100000000 |
| 4 | 5042 | 01010001010010 | 00000001010000 |
| 5 | 8192 | 10000000000000 | 00000000000000 |
| 6 | 0 | 00000000000000 | 00000000000000 |
| 7 | -8191 | 10000000000001 | 10000000000000 |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| clear_i | input | 1 | Clear the accumulator before adding this product |
| coef_idx_i | input | 3 | Constant index, per R2 |
| data_i | input | 16 | Signed operand |
| result_o | output | 21 | Accumulated sum, integer part (sum >>> 14) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the cases where shift-add arithmetic goes subtly wrong, and says what a faulty design would show in each.
- A -1 digit must subtract exactly. A design that drops the carry-in would come out low by one least-significant fraction unit per negative digit, and the floor then exposes the error for many operands.
- The operand -32768 times -8191, and the single-digit constant, exercise sign extension and the longest shift. A logical shift would turn negative products into large positive numbers.
- The zero-digit constant and the ignored start while busy test the control side. A wrong design would either hang, finish a cycle late, or take the second operand.
- The latency is compared with the digit count for every request. This catches a scanner that skips a digit or visits one twice.

// File: rtl/csd_mac_pkg.sv
package csd_mac_pkg;

  localparam int CODE_W = 14;
  localparam int IDX_W  = 3;
  localparam int SH_W   = $clog2(CODE_W + 1);

  typedef struct packed {
    logic [CODE_W-1:0] nz;   // 1 where the digit is +1 or -1
    logic [CODE_W-1:0] neg;  // 1 where the digit is -1
  } csd_code_t;

  // Signed-digit codes of the eight constants (value = K / 2^14).
  function automatic csd_code_t coef_lookup(input logic [IDX_W-1:0] idx);
    csd_code_t c;
    case (idx)
      3'd0:    begin c.nz = 14'b00000000010010; c.neg = 14'b00000000000000; end // 18
      3'd1:    begin c.nz = 14'b00000010010100; c.neg = 14'b00000010000100; end // -116
      3'd2:    begin c.nz = 14'b00001001010101; c.neg = 14'b00000001010100; end // 429
      3'd3:    begin c.nz = 14'b00010100000010; c.neg = 14'b00010100000000; end // -1278
      3'd4:    begin c.nz = 14'b01010001010010; c.neg = 14'b00000001010000; end // 5042
      3'd5:    begin c.nz = 14'b10000000000000; c.neg = 14'b00000000000000; end // 8192
      3'd6:    begin c.nz = 14'b00000000000000; c.neg = 14'b00000000000000; end // 0
      default: begin c.nz = 14'b10000000000001; c.neg = 14'b10000000000000; end // -8191
    endcase
    return c;
  endfunction

  // Position of the most significant set bit (0 when the mask is empty).
  function automatic logic [SH_W-1:0] top_digit(input logic [CODE_W-1:0] m);
    logic [SH_W-1:0] r;
    r = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (m[i]) r = SH_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/csd_digit_ctrl.sv
module csd_digit_ctrl
  import csd_mac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  csd_code_t       code_i,
  output logic            step_o,
  output logic            last_o,
  output logic [SH_W-1:0] shift_o,
  output logic            inv_o
);

  logic [CODE_W-1:0] nz_q, neg_q, nz_rest;
  logic [SH_W-1:0]   pos;

  always_comb begin
    pos     = top_digit(nz_q);
    step_o  = |nz_q;
    nz_rest = nz_q & ~(CODE_W'(1) << pos);
    last_o  = step_o && (nz_rest == '0);
    shift_o = SH_W'(CODE_W) - pos;
    inv_o   = step_o && neg_q[pos];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nz_q  <= '0;
      neg_q <= '0;
    end else if (load_i) begin
      nz_q  <= code_i.nz;
      neg_q <= code_i.neg;
    end else if (step_o) begin
      nz_q  <= nz_rest;
    end
  end

  AST_ONE_DIGIT_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !load_i) |=> ($countones(nz_q) == $countones($past(nz_q)) - 1)); // R5

  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (shift_o >= SH_W'(1) && shift_o <= SH_W'(CODE_W))); // R8

endmodule

// File: rtl/csd_shift_alu.sv
module csd_shift_alu #(
  parameter int DW    = 16,
  parameter int FRAC  = 14,
  parameter int ACC_W = 35,
  parameter int SH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    op_i,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             inv_i,
  output logic [ACC_W-1:0] acc_o
);

  localparam int EXT_W = ACC_W - DW - FRAC;

  // Operand placed with FRAC fraction bits, then shifted arithmetically.
  function automatic logic [ACC_W-1:0] scaled_term(input logic [DW-1:0] x,
                                                   input logic [SH_W-1:0] sh);
    logic signed [ACC_W-1:0] w;
    w = signed'({{EXT_W{x[DW-1]}}, x, {FRAC{1'b0}}});
    return ACC_W'(w >>> sh);
  endfunction

  logic [ACC_W-1:0] acc_q, term, addend, sum;
  logic             ovf;

  always_comb begin
    term   = scaled_term(op_i, shift_i);
    addend = inv_i ? ~term : term;
    sum    = acc_q + addend + {{(ACC_W-1){1'b0}}, inv_i};
    ovf    = (acc_q[ACC_W-1] == addend[ACC_W-1]) && (sum[ACC_W-1] != acc_q[ACC_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= sum;
  end

  assign acc_o = acc_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !ovf); // R9

endmodule

// File: rtl/csd_serial_mac.sv
module csd_serial_mac
  import csd_mac_pkg::*;
#(
  parameter  int DW    = 16,
  parameter  int GUARD = 4,
  localparam int ACC_W = DW + 1 + CODE_W + GUARD,
  localparam int RES_W = ACC_W - CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic [IDX_W-1:0] coef_idx_i,
  input  logic [DW-1:0]    data_i,
  output logic [RES_W-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);

  logic            busy_q, done_q, accept, finish;
  logic [DW-1:0]   op_q;
  csd_code_t       code;
  logic            step, last, inv;
  logic [SH_W-1:0] shift;
  logic [ACC_W-1:0] acc;

  assign accept = start_i && !busy_q;
  assign finish = busy_q && (!step || last);
  assign code   = coef_lookup(coef_idx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= data_i;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  csd_digit_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .code_i  (code),
    .step_o  (step),
    .last_o  (last),
    .shift_o (shift),
    .inv_o   (inv)
  );

  csd_shift_alu #(
    .DW    (DW),
    .FRAC  (CODE_W),
    .ACC_W (ACC_W),
    .SH_W  (SH_W)
  ) u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_q),
    .clr_i   (accept && clear_i),
    .step_i  (step),
    .shift_i (shift),
    .inv_i   (inv),
    .acc_o   (acc)
  );

  assign result_o = acc[ACC_W-1:CODE_W];
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R5

  AST_STEP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy_q); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(op_q)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> $stable(result_o)); // R8

endmodule

// File: tb/csd_serial_mac_bench.sv
`timescale 1ns/1ps
module csd_serial_mac_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [2:0]  coef_idx_i = '0;
  logic [15:0] data_i = '0;
  logic [20:0] result_o;
  logic        busy_o, done_o;

  always #2.5 clk = ~clk;

  csd_serial_mac u_csd_serial_mac (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .coef_idx_i(coef_idx_i), .data_i(data_i),
    .result_o(result_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct {
    longint exp_res;
    int     start_cyc;
    int     lat;
    string  tag;
  } sb_item_t;

  sb_item_t sb[$];
  int       checks = 0;
  int       fails  = 0;
  int       cyc    = 0;
  longint   model  = 0;
  int       acc_n  = 0;
  bit       finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint kval(input int idx);
    case (idx)
      0: return 18;     1: return -116;  2: return 429;   3: return -1278;
      4: return 5042;   5: return 8192;  6: return 0;     default: return -8191;
    endcase
  endfunction

  function automatic int ndig(input int idx);
    case (idx)
      0: return 2; 1: return 3; 2: return 5; 3: return 3;
      4: return 5; 5: return 1; 6: return 0; default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard on every completion pulse.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5 unexpected done", 1, 0);
      end else begin
        sb_item_t it;
        it = sb.pop_front();
        check($signed(result_o) == it.exp_res, it.tag, $signed(result_o), it.exp_res);
        check((cyc - it.start_cyc - 1) == it.lat, "R5 latency",
              cyc - it.start_cyc - 1, it.lat);
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o || done_o || sb.size() != 0) @(negedge clk);
  endtask

  task automatic run_op(input logic [15:0] x, input int idx, input bit clr,
                        input bit poke, input string tag);
    sb_item_t it;
    wait_idle();
    if (clr) begin model = 0; acc_n = 0; end
    model += longint'($signed(x)) * kval(idx);
    acc_n++;
    it.exp_res   = model >>> 14;
    it.start_cyc = cyc;
    it.lat       = (ndig(idx) > 0) ? ndig(idx) : 1;
    it.tag       = tag;
    sb.push_back(it);
    start_i = 1'b1; clear_i = clr; coef_idx_i = 3'(idx); data_i = x;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R5 busy after start", busy_o, 1);
    if (poke) begin
      // R6: second start while busy must be ignored
      start_i = 1'b1; clear_i = 1'b1; coef_idx_i = 3'd4; data_i = 16'h7ABC;
      @(negedge clk);
      start_i = 1'b0; clear_i = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(result_o == '0, "R1 result", result_o, 0);
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(done_o == 1'b0, "R1 done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: each constant against an integer product
    for (int k = 0; k < 8; k++) run_op(16'sd12345, k, 1'b1, 1'b0, "R2 R3 table product");
    for (int k = 0; k < 8; k++) run_op(-16'sd771, k, 1'b1, 1'b0, "R3 negative operand");

    // R9: extreme operands
    run_op(16'h8000, 7, 1'b1, 1'b0, "R9 min x -8191");
    run_op(16'h8000, 4, 1'b1, 1'b0, "R9 min x 5042");
    run_op(16'h7FFF, 5, 1'b1, 1'b0, "R9 max x 8192");
    run_op(16'h7FFF, 3, 1'b1, 1'b0, "R9 max x -1278");

    // R4: accumulate without clear, then clear
    run_op(16'sd1000, 2, 1'b1, 1'b0, "R4 first");
    run_op(16'sd2000, 1, 1'b0, 1'b0, "R4 accumulate");
    run_op(-16'sd3000, 4, 1'b0, 1'b0, "R4 accumulate");
    run_op(16'sd7, 0, 1'b1, 1'b0, "R4 clear");

    // R7: zero-digit constant
    run_op(16'sd9000, 4, 1'b1, 1'b0, "R7 setup");
    run_op(16'sd5555, 6, 1'b0, 1'b0, "R7 zero keeps sum");
    run_op(16'sd5555, 6, 1'b1, 1'b0, "R7 zero with clear");

    // R6: start while busy ignored
    run_op(16'sd321, 2, 1'b1, 1'b1, "R6 poke during 429");
    run_op(-16'sd4321, 6, 1'b0, 1'b1, "R6 poke during zero");

    // R8: idle hold
    wait_idle();
    begin
      logic [20:0] held;
      held = result_o;
      repeat (6) @(negedge clk);
      check(result_o == held, "R8 idle hold", result_o, held);
    end

    // R9: 64 full-scale accumulations
    run_op(16'h8000, 5, 1'b1, 1'b0, "R9 long sum");
    for (int i = 1; i < 64; i++) run_op(16'h8000, 7, 1'b0, 1'b0, "R9 long sum");

    // Random mix
    for (int i = 0; i < 120; i++) begin
      logic [15:0] x;
      int idx;
      bit clr;
      x   = 16'($urandom);
      idx = int'($urandom % 8);
      clr = (($urandom % 4) == 0) || (acc_n >= 30);
      run_op(x, idx, clr, (($urandom % 5) == 0), "R3 random");
    end

    wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule